// File: doc/BRIEF.md
# Ethernet MAC Startup Register Sequencer

This block brings up a high-speed Ethernet MAC core after power-on or reset. On a start pulse it writes three fixed control values into the MAC's register space through an AXI4-Lite master write port. The first write turns the receive path on. The second makes the transmitter send a remote fault indication while transmit stays off. The block then halts in a polling state until the MAC reports receive alignment. Only then does it issue the last write, which turns transmit on and stops the remote fault indication in one step.

The alignment status arrives from another clock domain, so it passes through a two-flop synchronizer before the sequencer looks at it. The block reports progress through a busy level, a one-cycle done pulse and a sticky error flag. The error flag records any write whose response is not OKAY. A write error does not stop the sequence.

Top module: `mac_bringup_seq`

## Requirements
- R1: After reset, busy, done, error, AWVALID, WVALID and BREADY are all low, and no write is issued until a start pulse is sampled.
- R2: The first write of a sequence uses byte address 0x00014 and data 0x00000001.
- R3: The second write uses byte address 0x0000C and data 0x00000010.
- R4: After the second write response, the block issues no further write until the synchronized alignment input is high. With alignment first sampled high at clock edge E, the third AWVALID is visible after edge E+3.
- R5: The third write, the last one, uses byte address 0x0000C and data 0x00000001.
- R6: AWVALID and WVALID rise together, and each stays high with stable payload until its own READY is seen. BREADY is high only after both have been accepted, and it stays high until BVALID. The next write starts only after that response.
- R7: Every write drives AWPROT = 3'b000 and WSTRB = 4'b1111.
- R8: A write response other than OKAY (2'b00) sets error one cycle later. Error stays set until the next accepted start, which clears it, and the remaining writes still take place.
- R9: Busy rises the cycle after an accepted start and falls the cycle after the last write response. Done is high for exactly that one cycle.
- R10: A start pulse while busy is ignored: that sequence still makes exactly three writes, and no extra sequence follows.
- R11: If alignment is already high when the wait begins, the third AWVALID is visible two edges after the edge of the second write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts one sequence when idle |
| rx_aligned_async | input | 1 | Receive alignment status, asynchronous |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write byte address |
| m_awprot | output | 3 | Protection type, always 0 |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes, all ones |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky non-OKAY response flag |

## Verification
The hardest situation to reach is a start pulse that lands while the block is parked waiting for alignment, combined with an error response on an earlier write. Both have to be present at once to show that the stray start neither restarts the script nor clears the error. The bench gets there by holding alignment low and marking the second response of a run as SLVERR. It waits until two responses of that run have been counted, and only then pulses start again and releases alignment. The alignment timing is checked from both sides: once with the input raised late in the wait, and once with it held high before the wait begins.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam int         STEPS      = 3;
  localparam int         STEP_W     = 2;
  localparam int         GATED_STEP = 2;   // step that must wait for alignment

  function automatic logic [31:0] step_addr(input logic [STEP_W-1:0] idx);
    case (idx)
      2'd0:    step_addr = 32'h0000_0014;
      default: step_addr = 32'h0000_000C;
    endcase
  endfunction

  function automatic logic [31:0] step_data(input logic [STEP_W-1:0] idx);
    case (idx)
      2'd1:    step_data = 32'h0000_0010;
      default: step_data = 32'h0000_0001;
    endcase
  endfunction

  // address+data phase ends in this cycle when every open channel handshakes
  function automatic logic phase_closes(input logic aw_open, input logic aw_hs,
                                        input logic w_open,  input logic w_hs);
    phase_closes = (aw_open || w_open) && (!aw_open || aw_hs) && (!w_open || w_hs);
  endfunction

endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lite_wr_engine.sv
module lite_wr_engine
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  input  logic              bvalid,
  output logic              bready,
  output logic              resp_fire
);
  logic aw_open, w_open, resp_ph;
  logic aw_hs, w_hs, eng_busy;

  assign aw_hs     = aw_open && awready;
  assign w_hs      = w_open && wready;
  assign eng_busy  = aw_open || w_open || resp_ph;
  assign resp_fire = resp_ph && bvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_open <= 1'b0;
      w_open  <= 1'b0;
      resp_ph <= 1'b0;
      awaddr  <= '0;
      wdata   <= '0;
    end else if (go && !eng_busy) begin
      aw_open <= 1'b1;
      w_open  <= 1'b1;
      awaddr  <= addr_in;
      wdata   <= data_in;
    end else begin
      if (aw_hs) aw_open <= 1'b0;
      if (w_hs)  w_open  <= 1'b0;
      if (resp_fire)
        resp_ph <= 1'b0;
      else if (phase_closes(aw_open, aw_hs, w_open, w_hs))
        resp_ph <= 1'b1;
    end
  end

  assign awvalid = aw_open;
  assign wvalid  = w_open;
  assign bready  = resp_ph;

  p_aw_hold_r6: assert property (@(posedge clk) disable iff (rst)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  p_w_hold_r6: assert property (@(posedge clk) disable iff (rst)
    wvalid && !wready |=> wvalid && $stable(wdata));
  p_bready_excl_r6: assert property (@(posedge clk) disable iff (rst)
    bready |-> !awvalid && !wvalid);
endmodule

// File: rtl/mac_bringup_seq.sv
module mac_bringup_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                rx_aligned_async,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [2:0]          m_awprot,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp,
  output logic                busy,
  output logic                done,
  output logic                error
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] HOLD_STEP = STEP_W'(GATED_STEP);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_XFER, ST_HOLD} seq_state_t;

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic              align_s, go, resp_fire, start_ok;

  level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(rx_aligned_async), .q(align_s)
  );

  assign go       = (state == ST_ISSUE);
  assign start_ok = (state == ST_IDLE) && start;

  lite_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .go(go),
    .addr_in(ADDR_W'(step_addr(step))), .data_in(DATA_W'(step_data(step))),
    .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr),
    .wvalid(m_wvalid), .wready(m_wready), .wdata(m_wdata),
    .bvalid(m_bvalid), .bready(m_bready), .resp_fire(resp_fire)
  );

  assign m_awprot = 3'b000;
  assign m_wstrb  = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ISSUE;
          step  <= '0;
          busy  <= 1'b1;
          error <= 1'b0;
        end
        ST_ISSUE: state <= ST_XFER;
        ST_XFER: if (resp_fire) begin
          if (m_bresp != RESP_OKAY) error <= 1'b1;
          if (step == LAST_STEP) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            step  <= step + 1'b1;
            state <= (step + 1'b1 == HOLD_STEP) ? ST_HOLD : ST_ISSUE;
          end
        end
        ST_HOLD: if (align_s) state <= ST_ISSUE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_gate_align_r4: assert property (@(posedge clk) disable iff (rst)
    go && step == HOLD_STEP |-> $past(align_s));
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    busy && !done && start && !resp_fire |=> busy);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    error && !start_ok |=> error);
endmodule

// File: tb/tb_mac_bringup_seq.sv
module tb_mac_bringup_seq;
  logic clk = 0, rst = 1, start = 0, align = 0;
  logic awvalid, awready = 0, wvalid, wready = 0, bvalid = 0, bready;
  logic [31:0] awaddr, wdata;
  logic [2:0]  awprot;
  logic [3:0]  wstrb;
  logic [1:0]  bresp = 2'b00;
  logic busy, done, error;

  always #4 clk = ~clk;  // 125 MHz

  mac_bringup_seq dut (
    .clk(clk), .rst(rst), .start(start), .rx_aligned_async(align),
    .m_awvalid(awvalid), .m_awready(awready), .m_awaddr(awaddr), .m_awprot(awprot),
    .m_wvalid(wvalid), .m_wready(wready), .m_wdata(wdata), .m_wstrb(wstrb),
    .m_bvalid(bvalid), .m_bready(bready), .m_bresp(bresp),
    .busy(busy), .done(done), .error(error)
  );

  int total = 0, bad = 0, cyc = 0;
  int lat_aw = 0, lat_w = 0, lat_b = 0, err_at = -1;
  int aw_wait = 0, w_wait = 0, b_wait = 0, b_total = 0;
  int aw_idx = 0, w_idx = 0, run_b = 0, run_aw = 0;
  int eb2 = -1, third_rise = -1, align_edge = -1;
  bit aw_prev = 0;

  // reference model state
  int m = 0, k = 0;
  bit r_aw = 0, r_w = 0, r_b = 0, r_busy = 0, r_done = 0, r_err = 0, al1 = 0, al2 = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] want_addr(input int i);
    return (i % 3 == 0) ? 32'h14 : 32'hC;
  endfunction
  function automatic logic [31:0] want_data(input int i);
    return (i % 3 == 1) ? 32'h10 : 32'h1;
  endfunction

  // slave timing counters and reference model, updated on the edge
  always @(posedge clk) begin
    bit hs_aw, hs_w, hs_b;
    cyc++;
    hs_aw = awvalid && awready;
    hs_w  = wvalid && wready;
    hs_b  = bvalid && bready;
    if (hs_aw) begin
      chk(awaddr == want_addr(aw_idx), (aw_idx % 3 == 0) ? "R2 addr" : (aw_idx % 3 == 1) ? "R3 addr" : "R5 addr",
          awaddr, want_addr(aw_idx));
      chk(awprot == 3'b000, "R7 awprot", 32'(awprot), 0);
      aw_idx++; run_aw++;
    end
    if (hs_w) begin
      chk(wdata == want_data(w_idx), (w_idx % 3 == 0) ? "R2 data" : (w_idx % 3 == 1) ? "R3 data" : "R5 data",
          wdata, want_data(w_idx));
      chk(wstrb == 4'hF, "R7 wstrb", 32'(wstrb), 32'hF);
      w_idx++;
    end
    aw_wait = hs_aw ? 0 : (awvalid ? aw_wait + 1 : 0);
    w_wait  = hs_w  ? 0 : (wvalid  ? w_wait + 1  : 0);
    if (hs_b) begin b_wait = 0; b_total++; end
    else if (bready) b_wait++;

    r_done = 0;
    if (rst) begin
      m = 0; r_aw = 0; r_w = 0; r_b = 0; r_busy = 0; r_err = 0;
    end else begin
      case (m)
        0: if (start) begin m = 1; r_busy = 1; r_err = 0; k = 0; run_b = 0; run_aw = 0; end
        1: begin r_aw = 1; r_w = 1; m = 2; end
        2: if (r_b && hs_b) begin
             r_b = 0;
             if (bresp != 2'b00) r_err = 1;
             k++; run_b++;
             if (run_b == 2) eb2 = cyc;
             if (k == 1) m = 1;
             else if (k == 2) m = 3;
             else begin m = 0; r_busy = 0; r_done = 1; end
           end else begin
             if (r_aw && hs_aw) r_aw = 0;
             if (r_w && hs_w) r_w = 0;
             if (!r_aw && !r_w) r_b = 1;
           end
        3: if (al2) m = 1;
        default: m = 0;
      endcase
    end
    al2 = al1; al1 = align;
  end

  // slave drive and per-cycle comparison, away from the edge
  always @(negedge clk) begin
    awready = awvalid && (aw_wait >= lat_aw);
    wready  = wvalid && (w_wait >= lat_w);
    bvalid  = bready && (b_wait >= lat_b);
    bresp   = (b_total == err_at) ? 2'b10 : 2'b00;
    if (awvalid && !aw_prev && run_b == 2) third_rise = cyc;
    aw_prev = awvalid;
    if (!rst) begin
      chk(awvalid == r_aw, "R6/R4 awvalid", 32'(awvalid), 32'(r_aw));
      chk(wvalid == r_w, "R6 wvalid", 32'(wvalid), 32'(r_w));
      chk(bready == r_b, "R6 bready", 32'(bready), 32'(r_b));
      chk(busy == r_busy, "R9 busy", 32'(busy), 32'(r_busy));
      chk(done == r_done, "R9 done", 32'(done), 32'(r_done));
      chk(error == r_err, "R8 error", 32'(error), 32'(r_err));
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_two_resp();
    while (run_b < 2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state and no activity without start
    chk(!busy && !done && !error, "R1 flags", {29'b0, busy, done, error}, 0);
    chk(!awvalid && !wvalid && !bready, "R1 channels", {29'b0, awvalid, wvalid, bready}, 0);
    repeat (20) @(negedge clk);
    chk(aw_idx == 0, "R1 idle writes", aw_idx, 0);

    // alignment raised late in the wait, fast slave
    lat_aw = 0; lat_w = 0; lat_b = 0;
    pulse_start();
    wait_two_resp();
    repeat (10) @(negedge clk);
    align = 1; align_edge = cyc + 1;
    wait_done();
    chk(third_rise == align_edge + 3, "R4 release timing", third_rise, align_edge + 3);
    chk(run_aw == 3, "R10 writes per run", run_aw, 3);

    // alignment already high, slow address channel and response
    lat_aw = 3; lat_w = 0; lat_b = 2;
    pulse_start();
    wait_done();
    chk(third_rise == eb2 + 2, "R11 pre-aligned timing", third_rise, eb2 + 2);

    // error on second write, stray start while waiting
    align = 0;
    repeat (4) @(negedge clk);
    lat_aw = 0; lat_w = 4; lat_b = 1;
    err_at = b_total + 1;
    pulse_start();
    wait_two_resp();
    @(negedge clk);
    chk(error == 1'b1, "R8 error set", 32'(error), 1);
    pulse_start();
    repeat (5) @(negedge clk);
    chk(busy == 1'b1 && error == 1'b1, "R10 start ignored", {30'b0, busy, error}, 3);
    align = 1;
    wait_done();
    err_at = -1;
    chk(error == 1'b1 && run_aw == 3, "R8 sticky, sequence continued", {error, 31'(run_aw)}, {1'b1, 31'd3});
    repeat (6) @(negedge clk);
    chk(aw_idx == 9, "R10 no extra run", aw_idx, 9);

    // next start clears error
    lat_aw = 1; lat_w = 1; lat_b = 0;
    pulse_start();
    chk(error == 1'b0, "R8 cleared by start", 32'(error), 0);
    wait_done();
    chk(aw_idx == 12 && w_idx == 12, "R5 full run count", aw_idx, 12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule